// File: doc/BRIEF.md
# Sixteen-bit waveform timer

This block is a 16-bit up-counter driven by a selectable clock divider. A 4-bit mode field picks one of three ways to count. In free-running mode it counts up and wraps. In clear-on-match mode it restarts from zero after reaching a programmable limit. In single-slope PWM mode it counts from zero to a limit and then starts again. The limit comes from compare register A, from the capture register, or from a fixed value, depending on the mode.

One compare output can toggle, clear or set when the count matches compare register A. It reaches the pin only when the pin direction enable is set. Three sticky flags report:
- a compare-A match,
- reaching a limit held in the capture register,
- an overflow.

Software writes the counter and both registers through a simple write port. It clears the flags by writing ones.

In clear-on-match mode, compare register A is written straight into the live register. A limit written below the current count therefore makes the counter run on through 0xFFFF. In PWM modes the same register is double-buffered and reloads when the count reaches its limit.

Top module: `timer16_wgen`

## Requirements
- R1: After reset the count is 0, all three flags are 0 and the output pin is 0.
- R2: `clk_sel` sets the tick rate. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter, which then holds its value.
- R3: In mode 0 the counter increments by one per tick and wraps from 0xFFFF to 0x0000. `flag_ovf` is set on the tick of that wrap.
- R4: In mode 4 the limit is compare register A. A tick at count equal to the limit loads 0, and the same tick sets `flag_cmp`.
- R5: In mode 12 the limit is the capture register. A tick at the limit loads 0 and sets `flag_cap`. `flag_cmp` is set only by a tick at a count equal to compare register A.
- R6: In modes 0, 4 and 12, a write to compare register A takes effect on the next tick. If the new value is below the count, no clear happens until the counter passes 0xFFFF, wraps to 0 (setting `flag_ovf`) and reaches the new value.
- R7: With `out_mode` 1, the internal output level inverts on every tick at a compare-A match. In mode 4 the pin therefore holds each level for N·(limit+1) clocks. With `out_mode` 2 a match clears the level, and with 3 it sets the level, in modes 0, 4 and 12.
- R8: Modes 5, 6 and 7 are PWM modes with fixed limits 0x00FF, 0x01FF and 0x03FF. The tick at the limit loads 0 and sets `flag_ovf`.
- R9: In PWM modes 14 and 15, a write to compare register A goes to a buffer. The live value changes only on a tick at the limit. Mode 15 uses compare register A as the limit and mode 14 uses the capture register.
- R10: In PWM modes with `out_mode` 2, the tick at the limit sets the level and a compare-A match clears it, so the pin is high while count ≤ compare A. With `out_mode` 3 the pin is the inverse. When both events fall on the same tick, the limit event wins.
- R11: `oc_pin` is 0 whenever `pin_dir` is 0 or `out_mode` is 0.
- R12: Each `flag_clr` bit clears its flag (bit 0 `flag_cmp`, bit 1 `flag_cap`, bit 2 `flag_ovf`). A flag set in the same cycle as its clear stays set.
- R13: A write with `wr_sel` 0 loads the count on the next edge and suppresses that cycle's tick. `wr_sel` 1 targets compare register A, 2 the capture register, and 3 nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 compare A, 2 capture, 3 none |
| wr_data | input | 16 | Write data |
| wave_mode | input | 4 | Counting mode (0, 4, 12, 5, 6, 7, 14, 15) |
| out_mode | input | 2 | Output action: 0 off, 1 toggle, 2 clear, 3 set |
| clk_sel | input | 3 | Divider select |
| pin_dir | input | 1 | Pin output enable |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| count | output | 16 | Current count |
| oc_pin | output | 1 | Compare output pin |
| flag_cmp | output | 1 | Compare-A match flag |
| flag_cap | output | 1 | Capture-limit flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The following properties are checked on every cycle:
- a stopped divider holds the count;
- each tick either increments the count or, at the limit, loads zero;
- a count write lands on the next edge;
- a compare match in toggle mode flips the output level;
- a flag rises only after a tick;
- in PWM modes, the live compare value changes only on a limit tick.

Only the bench scenarios can show the following:
- the measured divider periods and the toggle half-period;
- the run through 0xFFFF after a low limit is written;
- the deferred reload of a buffered value;
- the pin duty pattern in PWM;
- the set-over-clear priority of the flags.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    TOP_FULL  = 2'd0,
    TOP_FIXED = 2'd1,
    TOP_CMPA  = 2'd2,
    TOP_CAP   = 2'd3
  } top_src_e;

  typedef struct packed {
    logic     pwm;
    top_src_e src;
    logic [1:0] fix_sel;
  } mode_cfg_t;

  localparam logic [1:0] REG_COUNT = 2'd0;
  localparam logic [1:0] REG_CMPA  = 2'd1;
  localparam logic [1:0] REG_CAP   = 2'd2;

  localparam int FLG_CMP = 0;
  localparam int FLG_CAP = 1;
  localparam int FLG_OVF = 2;

  // Mode field decode: limit source and slope kind.
  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c.pwm = 1'b0;
    c.src = TOP_FULL;
    c.fix_sel = 2'd0;
    case (m)
      4'd4:  c.src = TOP_CMPA;
      4'd12: c.src = TOP_CAP;
      4'd5:  begin c.pwm = 1'b1; c.src = TOP_FIXED; c.fix_sel = 2'd0; end
      4'd6:  begin c.pwm = 1'b1; c.src = TOP_FIXED; c.fix_sel = 2'd1; end
      4'd7:  begin c.pwm = 1'b1; c.src = TOP_FIXED; c.fix_sel = 2'd2; end
      4'd14: begin c.pwm = 1'b1; c.src = TOP_CAP;  end
      4'd15: begin c.pwm = 1'b1; c.src = TOP_CMPA; end
      default: ;
    endcase
    return c;
  endfunction

  // Low divider bits that must all be one for a tick.
  function automatic logic [PRE_W-1:0] prescale_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    return 10'd7;
      3'd3:    return 10'd63;
      3'd4:    return 10'd255;
      3'd5:    return 10'd1023;
      default: return '0;
    endcase
  endfunction

  function automatic logic prescale_on(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  // Fixed PWM limits: 8, 9 or 10 bits of ones.
  function automatic int fixed_top(input logic [1:0] fs);
    return (1 << (8 + int'(fs))) - 1;
  endfunction
endpackage

// File: rtl/tmr16_prescale.sv
`timescale 1ns/1ps
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign mask = prescale_mask(clk_sel);
  assign tick = prescale_on(clk_sel) && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr16_cmp_reg.sv
`timescale 1ns/1ps
module tmr16_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             buffered,
  input  logic             reload,
  output logic [CNT_W-1:0] cmp_act
);
  logic [CNT_W-1:0] cmp_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_cmp) begin
        cmp_buf <= wr_data;
        if (!buffered) cmp_act <= wr_data;
      end
      if (buffered && reload) cmp_act <= cmp_buf;
    end
  end
endmodule

// File: rtl/tmr16_wave.sv
`timescale 1ns/1ps
module tmr16_wave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] out_mode,
  input  logic       pwm,
  input  logic       cmp_event,
  input  logic       top_event,
  output logic       oc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
    end else begin
      case (out_mode)
        2'd1: if (cmp_event) oc_q <= ~oc_q;
        2'd2: begin
          if (pwm && top_event) oc_q <= 1'b1;
          else if (cmp_event)   oc_q <= 1'b0;
        end
        2'd3: begin
          if (pwm && top_event) oc_q <= 1'b0;
          else if (cmp_event)   oc_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/timer16_wgen.sv
`timescale 1ns/1ps
module timer16_wgen
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [3:0]       wave_mode,
  input  logic [1:0]       out_mode,
  input  logic [2:0]       clk_sel,
  input  logic             pin_dir,
  input  logic [2:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             oc_pin,
  output logic             flag_cmp,
  output logic             flag_cap,
  output logic             flag_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  mode_cfg_t        cfg;
  logic             tick, step;
  logic             wr_cnt, wr_cmp, wr_cap;
  logic             at_top, top_event, cmp_event, ovf_event, cap_event;
  logic             oc_q;
  logic [CNT_W-1:0] count_q, cap_q, cmp_act, top_value;

  assign cfg    = decode_mode(wave_mode);
  assign wr_cnt = wr_en && (wr_sel == REG_COUNT);
  assign wr_cmp = wr_en && (wr_sel == REG_CMPA);
  assign wr_cap = wr_en && (wr_sel == REG_CAP);

  tmr16_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  tmr16_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmp   (wr_cmp),
    .wr_data  (wr_data),
    .buffered (cfg.pwm),
    .reload   (top_event),
    .cmp_act  (cmp_act)
  );

  always_comb begin
    case (cfg.src)
      TOP_FIXED: top_value = CNT_W'(fixed_top(cfg.fix_sel));
      TOP_CMPA:  top_value = cmp_act;
      TOP_CAP:   top_value = cap_q;
      default:   top_value = CNT_MAX;
    endcase
  end

  // Named internal events
  assign step      = tick && !wr_cnt;
  assign at_top    = (count_q == top_value);
  assign top_event = step && at_top;
  assign cmp_event = step && (count_q == cmp_act);
  assign ovf_event = step && (cfg.pwm ? at_top : (count_q == CNT_MAX));
  assign cap_event = top_event && (cfg.src == TOP_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (wr_cnt)    count_q <= wr_data;
    else if (top_event) count_q <= '0;
    else if (step)      count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (wr_cap) cap_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_cmp <= 1'b0;
      flag_cap <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      flag_cmp <= cmp_event || (flag_cmp && !flag_clr[FLG_CMP]);
      flag_cap <= cap_event || (flag_cap && !flag_clr[FLG_CAP]);
      flag_ovf <= ovf_event || (flag_ovf && !flag_clr[FLG_OVF]);
    end
  end

  tmr16_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_mode  (out_mode),
    .pwm       (cfg.pwm),
    .cmp_event (cmp_event),
    .top_event (top_event),
    .oc_q      (oc_q)
  );

  assign count  = count_q;
  assign oc_pin = pin_dir && (out_mode != 2'd0) && oc_q;
endmodule

// File: rtl/timer16_wgen_chk.sv
`timescale 1ns/1ps
module timer16_wgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cmp_act,
  input logic [2:0]       clk_sel,
  input logic [1:0]       out_mode,
  input logic             tick,
  input logic             wr_cnt,
  input logic             at_top,
  input logic             buffered,
  input logic             cmp_event,
  input logic             oc_q,
  input logic             flag_ovf,
  input logic             flag_cmp
);
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !wr_cnt) |=> $stable(count_q));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !at_top) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

  // R4
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && at_top) |=> (count_q == '0));

  // R13
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_q == $past(wr_data)));

  // R9
  buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && $past(buffered) && !$stable(cmp_act)) |-> $past(tick && !wr_cnt && at_top));

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd1 && cmp_event) |=> (oc_q != $past(oc_q)));

  // R12
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> $past(tick && !wr_cnt));

  // R12
  cmp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_cmp) |-> $past(tick && !wr_cnt));
endmodule

bind timer16_wgen timer16_wgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count_q   (count_q),
  .wr_data   (wr_data),
  .cmp_act   (cmp_act),
  .clk_sel   (clk_sel),
  .out_mode  (out_mode),
  .tick      (tick),
  .wr_cnt    (wr_cnt),
  .at_top    (at_top),
  .buffered  (cfg.pwm),
  .cmp_event (cmp_event),
  .oc_q      (oc_q),
  .flag_ovf  (flag_ovf),
  .flag_cmp  (flag_cmp)
);

// File: tb/test_timer16_wgen.sv
`timescale 1ns/1ps
module test_timer16_wgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [3:0]  wave_mode = 4'd0;
  logic [1:0]  out_mode = 2'd0;
  logic [2:0]  clk_sel = 3'd0;
  logic        pin_dir = 1'b0;
  logic [2:0]  flag_clr = 3'd0;
  logic [15:0] count;
  logic        oc_pin, flag_cmp, flag_cap, flag_ovf;

  int n_chk = 0;
  int n_fail = 0;

  timer16_wgen i_timer16_wgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wave_mode(wave_mode), .out_mode(out_mode), .clk_sel(clk_sel), .pin_dir(pin_dir),
    .flag_clr(flag_clr), .count(count), .oc_pin(oc_pin), .flag_cmp(flag_cmp),
    .flag_cap(flag_cap), .flag_ovf(flag_ovf)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic clr_flags();
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic cycles_to_change(input bit use_pin, input int lim, output int c);
    logic [15:0] p;
    p = use_pin ? {15'd0, oc_pin} : count;
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (((use_pin ? {15'd0, oc_pin} : count) == p) && (c < lim));
  endtask

  task automatic t_reset();
    check(count == 16'd0, "R1 count", count, 0);
    check({flag_cmp, flag_cap, flag_ovf} == 3'b000, "R1 flags", {flag_cmp, flag_cap, flag_ovf}, 0);
    check(oc_pin == 1'b0, "R1 pin", oc_pin, 0);
  endtask

  task automatic t_load();
    clk_sel = 3'd0;
    wr_reg(2'd0, 16'h1234);
    check(count == 16'h1234, "R13 load", count, 16'h1234);
    repeat (4) @(negedge clk);
    check(count == 16'h1234, "R2 stop code 0", count, 16'h1234);
    clk_sel = 3'd6;
    repeat (3) @(negedge clk);
    check(count == 16'h1234, "R2 stop code 6", count, 16'h1234);
    clk_sel = 3'd1;
    @(negedge clk);
    check(count == 16'h1235, "R2 divide by 1", count, 16'h1235);
    wr_reg(2'd0, 16'h0100);
    check(count == 16'h0100, "R13 write beats tick", count, 16'h0100);
    @(negedge clk);
    check(count == 16'h0101, "R13 resume", count, 16'h0101);
    wr_reg(2'd3, 16'h7777);
    check(count == 16'h0102, "R13 select 3 ignored", count, 16'h0102);
    clk_sel = 3'd0;
  endtask

  task automatic t_normal();
    clk_sel = 3'd0; wave_mode = 4'd0;
    wr_reg(2'd0, 16'hFFFD);
    clr_flags();
    clk_sel = 3'd1;
    @(negedge clk);
    @(negedge clk);
    check(count == 16'hFFFF && !flag_ovf, "R3 before wrap", {flag_ovf, count}, 16'hFFFF);
    @(negedge clk);
    check(count == 16'h0000, "R3 wrap", count, 0);
    check(flag_ovf == 1'b1, "R3 ovf flag", flag_ovf, 1);
    clk_sel = 3'd0;
    flag_clr = 3'b100;
    @(negedge clk);
    flag_clr = 3'b000;
    check(flag_ovf == 1'b0, "R12 clear ovf", flag_ovf, 0);
    wr_reg(2'd0, 16'hFFFF);
    clk_sel = 3'd1; flag_clr = 3'b100;
    @(negedge clk);
    clk_sel = 3'd0; flag_clr = 3'b000;
    check(flag_ovf == 1'b1, "R12 set wins", flag_ovf, 1);
  endtask

  task automatic t_ctc_a();
    int exp_c;
    bit seen;
    clk_sel = 3'd0; wave_mode = 4'd4;
    wr_reg(2'd1, 16'd5);
    wr_reg(2'd0, 16'd0);
    clr_flags();
    clk_sel = 3'd1;
    exp_c = 0; seen = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (exp_c == 5) begin exp_c = 0; seen = 1; end else exp_c++;
      check(count == 16'(exp_c), "R4 count", count, exp_c);
      check(flag_cmp == seen, "R4 cmp flag", flag_cmp, seen);
    end
    clk_sel = 3'd0;
  endtask

  task automatic t_ctc_cap();
    int exp_c;
    bit seen;
    clk_sel = 3'd0; wave_mode = 4'd12;
    wr_reg(2'd1, 16'd7);
    wr_reg(2'd2, 16'd3);
    wr_reg(2'd0, 16'd0);
    clr_flags();
    clk_sel = 3'd1;
    exp_c = 0; seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (exp_c == 3) begin exp_c = 0; seen = 1; end else exp_c++;
      check(count == 16'(exp_c), "R5 count", count, exp_c);
      check(flag_cap == seen, "R5 cap flag", flag_cap, seen);
    end
    check(flag_cmp == 1'b0, "R5 no cmp flag", flag_cmp, 0);
    clk_sel = 3'd0;
  endtask

  task automatic t_ctc_unbuf();
    logic [15:0] exp_c, top;
    bit cmp_seen, ovf_seen;
    clk_sel = 3'd0; wave_mode = 4'd4;
    wr_reg(2'd1, 16'hFFD0);
    wr_reg(2'd0, 16'hFFC0);
    clr_flags();
    clk_sel = 3'd1;
    exp_c = 16'hFFC0; top = 16'hFFD0; cmp_seen = 0; ovf_seen = 0;
    for (int i = 0; i < 80; i++) begin
      if (i == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd8; end
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
      if (exp_c == top) begin exp_c = 0; cmp_seen = 1; end
      else begin
        if (exp_c == 16'hFFFF) ovf_seen = 1;
        exp_c = exp_c + 1'b1;
      end
      if (i == 5) top = 16'd8;
      check(count == exp_c, "R6 count", count, exp_c);
      check(flag_cmp == cmp_seen, "R6 no early match", flag_cmp, cmp_seen);
    end
    check(ovf_seen && flag_ovf, "R6 passed through wrap", flag_ovf, 1);
    clk_sel = 3'd0;
  endtask

  task automatic t_toggle();
    int c;
    clk_sel = 3'd0; wave_mode = 4'd4;
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd0, 16'd0);
    out_mode = 2'd1; pin_dir = 1'b1;
    clk_sel = 3'd1;
    cycles_to_change(1'b1, 20, c);
    cycles_to_change(1'b1, 20, c);
    check(c == 3, "R7 half period N=1", c, 3);
    clk_sel = 3'd2;
    cycles_to_change(1'b1, 100, c);
    cycles_to_change(1'b1, 100, c);
    check(c == 24, "R7 half period N=8", c, 24);
    clk_sel = 3'd1; pin_dir = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(oc_pin == 1'b0, "R11 pin disabled", oc_pin, 0);
    end
    pin_dir = 1'b1; out_mode = 2'd3;
    repeat (4) @(negedge clk);
    check(oc_pin == 1'b1, "R7 set on match", oc_pin, 1);
    out_mode = 2'd0;
    @(negedge clk);
    check(oc_pin == 1'b0, "R11 output mode off", oc_pin, 0);
    out_mode = 2'd2;
    repeat (4) @(negedge clk);
    check(oc_pin == 1'b0, "R7 clear on match", oc_pin, 0);
    clk_sel = 3'd0; out_mode = 2'd0; pin_dir = 1'b0;
  endtask

  task automatic t_fixed();
    logic [15:0] tops [3];
    tops[0] = 16'h00FF; tops[1] = 16'h01FF; tops[2] = 16'h03FF;
    for (int k = 0; k < 3; k++) begin
      clk_sel = 3'd0; wave_mode = 4'(5 + k);
      wr_reg(2'd0, tops[k] - 16'd1);
      clr_flags();
      clk_sel = 3'd1;
      @(negedge clk);
      check(count == tops[k] && !flag_ovf, "R8 at limit", count, tops[k]);
      @(negedge clk);
      check(count == 16'd0, "R8 restart", count, 0);
      check(flag_ovf == 1'b1, "R8 ovf at limit", flag_ovf, 1);
      clk_sel = 3'd0;
    end
  endtask

  task automatic t_buffered();
    int exp_c, top_act, buf_v;
    clk_sel = 3'd0; wave_mode = 4'd4;
    wr_reg(2'd1, 16'd10);
    wr_reg(2'd0, 16'd0);
    wave_mode = 4'd15;
    clk_sel = 3'd1;
    exp_c = 0; top_act = 10; buf_v = 10;
    for (int i = 0; i < 24; i++) begin
      if (i == 6) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd4; end
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
      if (exp_c == top_act) begin exp_c = 0; top_act = buf_v; end
      else exp_c++;
      if (i == 6) buf_v = 4;
      check(count == 16'(exp_c), "R9 buffered limit", count, exp_c);
    end
    clk_sel = 3'd0;
  endtask

  task automatic t_pwm_out();
    clk_sel = 3'd0; wave_mode = 4'd4;
    wr_reg(2'd1, 16'd3);
    wr_reg(2'd2, 16'd9);
    wr_reg(2'd0, 16'd0);
    wave_mode = 4'd14; out_mode = 2'd2; pin_dir = 1'b1;
    clk_sel = 3'd1;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(oc_pin == (count <= 16'd3), "R10 non-inverting", oc_pin, count <= 16'd3);
    end
    out_mode = 2'd3;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(oc_pin == (count > 16'd3), "R10 inverting", oc_pin, count > 16'd3);
    end
    clk_sel = 3'd0; out_mode = 2'd0; pin_dir = 1'b0;
  endtask

  task automatic t_rates();
    int c, n;
    wave_mode = 4'd0;
    for (int k = 2; k <= 5; k++) begin
      clk_sel = 3'(k);
      n = (k == 2) ? 8 : (k == 3) ? 64 : (k == 4) ? 256 : 1024;
      cycles_to_change(1'b0, 2100, c);
      cycles_to_change(1'b0, 2100, c);
      check(c == n, "R2 tick period", c, n);
    end
    clk_sel = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_normal();
    t_ctc_a();
    t_ctc_cap();
    t_ctc_unbuf();
    t_toggle();
    t_fixed();
    t_buffered();
    t_pwm_out();
    t_rates();
    report();
    $finish;
  end
endmodule